// File: doc/BRIEF.md
# Run-Ahead Stall Controller for Load Misses

This control block sits in the issue stage of an in-order core. When a data-cache load misses, the pipeline need not stop at once. Independent work may keep issuing in the shadow of the miss, up to a small fixed budget. The controller watches each candidate instruction in the cycle before it issues. It raises `stall` as soon as that instruction would break one of the budget rules. It drops `stall` again in the cycle the miss data comes back.

The limit checks are combinational on the candidate instruction, so no instruction past a limit ever issues. An instruction counts as issued in a cycle where `iss_valid` is high and `stall` is low. The controller tracks three counts for one open miss window: all instructions in flight, FP instructions and branches. It also keeps the destination register of the missing load. The counts are brought out for debug.

`miss_start` is raised in the cycle in which the missing load itself issues. That load is the first instruction of the window. The cache, the refill path and the commit datapath are not part of this block.

Top module: `runahead_stall_ctrl`

## Requirements
- R1: While a miss is open, `cnt_total` holds the number of instructions in flight, starting at 1 for the missing load. Once it reaches 8, `stall` is high whatever the candidate.
- R2: A valid candidate stalls if any of its valid source fields equals the open miss's destination register. A source field whose valid bit is low is never compared.
- R3: A valid candidate of class code 3 (memory, load or store) stalls while a miss is open.
- R4: FP instructions have class code 1. Once `cnt_fp` reaches 4 under an open miss, `stall` is high whatever the candidate.
- R5: A valid candidate of class code 4 (128-bit vector) stalls while a miss is open.
- R6: Branches have class code 2. With 3 branches in flight under the miss, a branch candidate stalls, while a non-branch candidate with no other hazard issues.
- R7: In the cycle `miss_return` is high for an open miss, `stall` is low. From the next cycle on, all three counts read 0 and no window is open.
- R8: Only one window is tracked. A `miss_start` while a window is open is ignored, and the dependency check keeps using the first miss's register.
- R9: When `miss_start` and `miss_return` are high in the same cycle with no window open, no window opens and the counts stay 0.
- R10: With no miss open, `stall` is low for every class and register, and issued instructions are not counted. Class code 0 is plain integer work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | A candidate instruction is ready to issue |
| iss_class | input | 3 | Candidate class: 0 int, 1 FP, 2 branch, 3 memory, 4 vector |
| iss_src | input | NUM_SRC*RW | Packed source register indices of the candidate |
| iss_src_vld | input | NUM_SRC | Per-source valid bits |
| miss_start | input | 1 | The missing load issues this cycle |
| miss_dst | input | RW | Destination register of the missing load |
| miss_return | input | 1 | The miss data returns this cycle |
| stall | output | 1 | Hold the candidate; it does not issue |
| cnt_total | output | CW | Instructions in flight under the miss |
| cnt_fp | output | CW | FP instructions in flight under the miss |
| cnt_br | output | CW | Branches in flight under the miss |

## Verification
The embedded assertions check on every cycle that no count goes past its limit, that `stall` only appears with an open window, and that a return releases the stall and clears the counts. They also check that a second miss leaves the recorded register untouched and that a coincident start and return opens nothing. Whether the stall appears on exactly the right candidate can only be shown by the bench's scenarios. This covers the eighth in-flight instruction, the fourth FP, the fourth branch, a consumer on either source port, and memory or vector work. The bench compares every cycle against its behavioural model while driving these patterns, both in isolation and mixed.

// File: rtl/rah_pkg.sv
package rah_pkg;
   typedef enum logic [2:0] {
      CLS_INT = 3'd0,
      CLS_FP  = 3'd1,
      CLS_BR  = 3'd2,
      CLS_MEM = 3'd3,
      CLS_VEC = 3'd4
   } iclass_e;
endpackage

// File: rtl/rah_window.sv
module rah_window #(
   parameter int RW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          miss_start,
   input  logic          miss_return,
   input  logic [RW-1:0] miss_dst,
   output logic          pending,
   output logic [RW-1:0] pend_dst
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pending  <= 1'b0;
         pend_dst <= '0;
      end else if (pending) begin
         if (miss_return) pending <= 1'b0;
      end else if (miss_start && !miss_return) begin
         pending  <= 1'b1;
         pend_dst <= miss_dst;
      end
   end

   // R8
   hold_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pending && !miss_return |=> pending && $stable(pend_dst));

   // R9
   no_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pending && miss_start && miss_return |=> !pending);
endmodule

// File: rtl/rah_counter.sv
module rah_counter #(
   parameter int LIMIT = 8,
   parameter int W     = 4,
   parameter int LOAD  = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         load,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] LOAD_V = W'(LOAD);
   localparam logic [W-1:0] LIM_V  = W'(LIMIT);

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt <= '0;
      else if (clr)  cnt <= '0;
      else if (load) cnt <= LOAD_V;
      else if (inc)  cnt <= cnt + 1'b1;
   end

   // R1 R4 R6
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inc && !clr && !load |-> cnt < LIM_V);
endmodule

// File: rtl/rah_hazard.sv
module rah_hazard #(
   parameter int RW       = 5,
   parameter int W        = 4,
   parameter int NUM_SRC  = 2,
   parameter int MAX_INFL = 8,
   parameter int MAX_FP   = 4,
   parameter int MAX_BR   = 3
) (
   input  logic                  pending,
   input  logic                  miss_return,
   input  logic [RW-1:0]         pend_dst,
   input  logic                  iss_valid,
   input  rah_pkg::iclass_e      iss_cls,
   input  logic [NUM_SRC*RW-1:0] iss_src,
   input  logic [NUM_SRC-1:0]    iss_src_vld,
   input  logic [W-1:0]          cnt_total,
   input  logic [W-1:0]          cnt_fp,
   input  logic [W-1:0]          cnt_br,
   output logic                  stall
);
   localparam logic [W-1:0] INFL_V = W'(MAX_INFL);
   localparam logic [W-1:0] FP_V   = W'(MAX_FP);
   localparam logic [W-1:0] BR_V   = W'(MAX_BR);

   logic [NUM_SRC-1:0] src_hit;
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      assign src_hit[i] = iss_src_vld[i] && (iss_src[i*RW +: RW] == pend_dst);
   end

   logic limit_hit, cls_block;
   always_comb begin
      limit_hit = (cnt_total >= INFL_V) || (cnt_fp >= FP_V);
      cls_block = iss_valid && ((|src_hit) ||
                                (iss_cls == rah_pkg::CLS_MEM) ||
                                (iss_cls == rah_pkg::CLS_VEC) ||
                                ((iss_cls == rah_pkg::CLS_BR) && (cnt_br >= BR_V)));
      stall = pending && !miss_return && (limit_hit || cls_block);
   end
endmodule

// File: rtl/runahead_stall_ctrl.sv
module runahead_stall_ctrl #(
   parameter int NREGS    = 32,
   parameter int NUM_SRC  = 2,
   parameter int MAX_INFL = 8,
   parameter int MAX_FP   = 4,
   parameter int MAX_BR   = 3,
   localparam int RW      = $clog2(NREGS),
   localparam int CW      = $clog2(MAX_INFL + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  iss_valid,
   input  logic [2:0]            iss_class,
   input  logic [NUM_SRC*RW-1:0] iss_src,
   input  logic [NUM_SRC-1:0]    iss_src_vld,
   input  logic                  miss_start,
   input  logic [RW-1:0]         miss_dst,
   input  logic                  miss_return,
   output logic                  stall,
   output logic [CW-1:0]         cnt_total,
   output logic [CW-1:0]         cnt_fp,
   output logic [CW-1:0]         cnt_br
);
   if (NREGS < 2 || NUM_SRC < 1 || MAX_INFL < 2 ||
       MAX_FP < 1 || MAX_FP >= MAX_INFL || MAX_BR < 1 || MAX_BR >= MAX_INFL) begin : g_bad_cfg
      $error("runahead_stall_ctrl: illegal parameter set");
   end

   rah_pkg::iclass_e cls;
   assign cls = rah_pkg::iclass_e'(iss_class);

   logic          pending;
   logic [RW-1:0] pend_dst;

   rah_window #(.RW(RW)) u_win (
      .clk(clk), .rst_n(rst_n), .miss_start(miss_start), .miss_return(miss_return),
      .miss_dst(miss_dst), .pending(pending), .pend_dst(pend_dst)
   );

   logic issued, win_clr, win_load, under;
   assign issued   = iss_valid && !stall;
   assign under    = pending && !miss_return && issued;
   assign win_clr  = pending && miss_return;
   assign win_load = !pending && miss_start && !miss_return;

   logic [2:0]    inc_v;
   logic [CW-1:0] cnt_q [3];
   assign inc_v[0] = under;
   assign inc_v[1] = under && (cls == rah_pkg::CLS_FP);
   assign inc_v[2] = under && (cls == rah_pkg::CLS_BR);

   for (genvar g = 0; g < 3; g++) begin : g_cnt
      localparam int LIM = (g == 0) ? MAX_INFL : (g == 1) ? MAX_FP : MAX_BR;
      localparam int LDV = (g == 0) ? 1 : 0;
      rah_counter #(.LIMIT(LIM), .W(CW), .LOAD(LDV)) u_cnt (
         .clk(clk), .rst_n(rst_n), .clr(win_clr), .load(win_load),
         .inc(inc_v[g]), .cnt(cnt_q[g])
      );
   end

   assign cnt_total = cnt_q[0];
   assign cnt_fp    = cnt_q[1];
   assign cnt_br    = cnt_q[2];

   rah_hazard #(.RW(RW), .W(CW), .NUM_SRC(NUM_SRC), .MAX_INFL(MAX_INFL),
                .MAX_FP(MAX_FP), .MAX_BR(MAX_BR)) u_haz (
      .pending(pending), .miss_return(miss_return), .pend_dst(pend_dst),
      .iss_valid(iss_valid), .iss_cls(cls), .iss_src(iss_src),
      .iss_src_vld(iss_src_vld), .cnt_total(cnt_total), .cnt_fp(cnt_fp),
      .cnt_br(cnt_br), .stall(stall)
   );

   // R10
   stall_needs_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> pending);

   // R7
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pending && miss_return |-> !stall);

   // R7
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pending && miss_return |=> cnt_total == '0 && cnt_fp == '0 && cnt_br == '0);

   // R1
   start_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pending && miss_start && !miss_return |=> cnt_total == CW'(1));
endmodule

// File: tb/runahead_stall_ctrl_tb.sv
module runahead_stall_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int RW = 5;

   logic clk = 0, rst_n = 0;
   logic iss_valid = 0;
   logic [2:0] iss_class = 0;
   logic [2*RW-1:0] iss_src = 0;
   logic [1:0] iss_src_vld = 0;
   logic miss_start = 0, miss_return = 0;
   logic [RW-1:0] miss_dst = 0;
   logic stall;
   logic [3:0] cnt_total, cnt_fp, cnt_br;

   runahead_stall_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_class(iss_class),
      .iss_src(iss_src), .iss_src_vld(iss_src_vld), .miss_start(miss_start),
      .miss_dst(miss_dst), .miss_return(miss_return), .stall(stall),
      .cnt_total(cnt_total), .cnt_fp(cnt_fp), .cnt_br(cnt_br)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int errors = 0, checks = 0;
   string tag = "R10";
   bit done = 0;

   // behavioural reference state
   bit m_pend = 0;
   int m_dst = 0, m_tot = 0, m_fp = 0, m_br = 0;
   bit m_stall;

   task automatic check(string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic bit model_stall();
      bit dep;
      dep = (iss_src_vld[0] && int'(iss_src[RW-1:0]) == m_dst) ||
            (iss_src_vld[1] && int'(iss_src[2*RW-1:RW]) == m_dst);
      if (!m_pend || miss_return) return 0;
      if (m_tot >= 8 || m_fp >= 4) return 1;
      if (!iss_valid) return 0;
      return dep || iss_class == 3 || iss_class == 4 || (iss_class == 2 && m_br >= 3);
   endfunction

   // inputs already driven after a falling edge; compare, then advance one clock
   task automatic step();
      #1;
      m_stall = model_stall();
      check("stall", int'(stall), int'(m_stall));
      check("cnt_total", int'(cnt_total), m_tot);
      check("cnt_fp", int'(cnt_fp), m_fp);
      check("cnt_br", int'(cnt_br), m_br);
      @(posedge clk);
      if (m_pend && miss_return) begin
         m_pend = 0; m_tot = 0; m_fp = 0; m_br = 0;
      end else if (!m_pend) begin
         if (miss_start && !miss_return) begin
            m_pend = 1; m_dst = int'(miss_dst); m_tot = 1; m_fp = 0; m_br = 0;
         end
      end else if (iss_valid && !m_stall) begin
         m_tot++;
         if (iss_class == 1) m_fp++;
         if (iss_class == 2) m_br++;
      end
      @(negedge clk);
   endtask

   task automatic drive(bit v, int cls, int sa, bit sav, int sb, bit sbv,
                        bit ms, int md, bit mr);
      iss_valid = v; iss_class = 3'(cls);
      iss_src = {RW'(sb), RW'(sa)}; iss_src_vld = {sbv, sav};
      miss_start = ms; miss_dst = RW'(md); miss_return = mr;
      step();
   endtask

   task automatic open_miss(int d);
      drive(1, 3, 1, 1, 0, 0, 1, d, 0);
   endtask
   task automatic close_miss();
      drive(1, 0, 1, 1, 0, 0, 0, 0, 1);
      drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      @(negedge clk); @(negedge clk);
      rst_n = 1;
      tag = "R10"; // reset state and no-miss behaviour
      for (int c = 0; c < 5; c++) drive(1, c, 7, 1, 7, 1, 0, 0, 0);

      tag = "R1"; // total limit of 8 including the load
      open_miss(5);
      for (int i = 0; i < 10; i++) drive(1, 0, 2, 1, 3, 1, 0, 0, 0);
      tag = "R7";
      close_miss();

      tag = "R2"; // consumer on either source
      open_miss(9);
      drive(1, 0, 9, 1, 0, 0, 0, 0, 0);
      drive(1, 0, 9, 0, 1, 1, 0, 0, 0);
      drive(1, 0, 0, 0, 9, 1, 0, 0, 0);
      drive(1, 0, 4, 1, 9, 0, 0, 0, 0);
      tag = "R3";
      drive(1, 3, 1, 1, 2, 1, 0, 0, 0);
      tag = "R5";
      drive(1, 4, 1, 1, 2, 1, 0, 0, 0);
      tag = "R8"; // second miss ignored
      drive(0, 0, 0, 0, 0, 0, 1, 12, 0);
      drive(1, 0, 12, 1, 0, 0, 0, 0, 0);
      drive(1, 0, 9, 1, 0, 0, 0, 0, 0);
      tag = "R7";
      close_miss();

      tag = "R4"; // four FP stalls everything
      open_miss(3);
      for (int i = 0; i < 6; i++) drive(1, 1, 1, 1, 2, 1, 0, 0, 0);
      drive(1, 0, 1, 1, 0, 0, 0, 0, 0);
      tag = "R7";
      close_miss();

      tag = "R6"; // fourth branch stalls, integer still issues
      open_miss(3);
      for (int i = 0; i < 4; i++) drive(1, 2, 1, 1, 0, 0, 0, 0, 0);
      drive(1, 0, 1, 1, 0, 0, 0, 0, 0);
      drive(1, 2, 1, 1, 0, 0, 0, 0, 0);
      tag = "R7";
      close_miss();

      tag = "R9"; // start and return together
      drive(1, 3, 0, 0, 0, 0, 1, 6, 1);
      drive(1, 0, 6, 1, 0, 0, 0, 0, 0);
      drive(1, 3, 0, 0, 0, 0, 0, 0, 0);

      tag = "R1"; // mixed classes
      open_miss(20);
      drive(1, 1, 1, 1, 0, 0, 0, 0, 0);
      drive(1, 2, 1, 1, 0, 0, 0, 0, 0);
      drive(1, 1, 1, 1, 0, 0, 0, 0, 0);
      drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
      for (int i = 0; i < 6; i++) drive(1, (i % 3 == 0) ? 2 : 0, 2, 1, 0, 0, 0, 0, 0);
      tag = "R7";
      close_miss();
      tag = "R10";
      drive(1, 4, 20, 1, 0, 0, 0, 0, 0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule